// File: doc/BRIEF.md
# Timer-to-ADC Cross Trigger Unit

This block lets timer events start ADC conversions with no processor in the path. Each of up to 64 event inputs has its own configuration word. The word enables the input, names the ADC channel to convert, and says what kind of timer drives the input. When an enabled event fires and the unit is free, a conversion request with that channel appears on the ADC side in the very next cycle. If the source is a periodic timer, the unit also sends it a one-cycle acknowledge pulse so that the timer can drop its flag. A capture/compare timer clears its own flag, so it gets no pulse.

Only one triggered conversion is in flight at a time. Events that arrive while the unit is busy, or that lose arbitration, are remembered per source and served later, lowest index first. A source that fires again before it has been served raises its overrun bit. If the ADC is busy with a normal-mode conversion when a triggered request goes out, the unit raises a hold output. That output tells the ADC to suspend the normal conversion and to resume it once the triggered one has ended.

Top module: `xtrig_unit`

## Requirements
- R1: The configuration word of source n is written with `cfg_we` at address n. Its layout is: bit 8 enable, bit 7 kind (1 = periodic timer, 0 = capture/compare timer), bits 6:0 ADC channel. `cfg_rdata` shows the word at `cfg_addr`. Every word is zero after reset.
- R2: An enabled source whose `evt_in` bit is high at a clock edge while the unit is idle raises `conv_req` after that same edge. `conv_chan` then carries that source's channel. Events on disabled sources cause no request, no acknowledge and no overrun.
- R3: When several candidate sources are present in the same idle cycle, the lowest index is issued first. The others are kept pending and issued later in ascending order.
- R4: A periodic-kind source gets exactly one single-cycle `src_ack` pulse on its own bit, in the same cycle that `conv_req` rises for it. A capture-kind source gets none.
- R5: `conv_req` stays high with a stable `conv_chan` until `conv_ack` is seen. The unit then stays busy until `conv_eoc`, and it issues no other request in the meantime.
- R6: An enabled event that arrives while the unit is busy becomes pending. A second event from a source that is already pending sets that source's bit in `ovr_flags`. A configuration write to a source clears both its pending state and its overrun bit.
- R7: `conv_eoc` while busy pulses `eoc_flag` for one cycle and returns the unit to idle. The next pending request rises one cycle after that.
- R8: If `norm_busy` is high in the cycle a request is issued, `norm_hold` rises together with `conv_req` and stays high until the edge that samples `conv_eoc`. Otherwise `norm_hold` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Source index for write and readback |
| cfg_wdata | input | 9 | Configuration word to write |
| cfg_rdata | output | 9 | Configuration word of the addressed source |
| evt_in | input | 64 | Timer event inputs, one per source |
| src_ack | output | 64 | Flag acknowledge pulses to periodic sources |
| ovr_flags | output | 64 | Per-source overrun bits |
| conv_req | output | 1 | Triggered conversion request to the ADC |
| conv_chan | output | 7 | Channel of the requested conversion |
| conv_ack | input | 1 | ADC accepts the request |
| conv_eoc | input | 1 | ADC end of triggered conversion |
| norm_busy | input | 1 | ADC is running a normal-mode conversion |
| norm_hold | output | 1 | Suspend the normal conversion while the triggered one runs |
| eoc_flag | output | 1 | End-of-triggered-conversion pulse |

## Verification
The hardest situation to reach is the overrun. A source must fire twice while it is already pending, which needs a conversion held open long enough for the repeat to land. The stimulus issues one request and withholds `conv_ack`. While the request is held, it fires a second source twice. This checks at once that the request and its channel stay stable and that only the repeated source is flagged. The preemption case is reached the same way, with `norm_busy` raised before the triggering event, and the hold output is then tracked through both handshake phases.

// File: rtl/xtu_pkg.sv
package xtu_pkg;
  localparam int CHAN_W = 7;

  typedef struct packed {
    logic              en;
    logic              periodic;
    logic [CHAN_W-1:0] chan;
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_CONV} seq_st_t;
endpackage

// File: rtl/xtu_cfg_bank.sv
module xtu_cfg_bank
  import xtu_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int ADDR_W = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  cfg_t                   wdata,
  output cfg_t                   rdata,
  input  logic [ADDR_W-1:0]      sel,
  output logic [CHAN_W-1:0]      sel_chan,
  output logic [NUM_SRC-1:0]     en_mask,
  output logic [NUM_SRC-1:0]     per_mask
);
  cfg_t cfg_q [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    logic wr_en;
    assign wr_en = we && (addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q[g] <= '0;
      else if (wr_en) cfg_q[g] <= wdata;
    end

    assign en_mask[g]  = cfg_q[g].en;
    assign per_mask[g] = cfg_q[g].periodic;
  end

  assign rdata    = cfg_q[addr];
  assign sel_chan = cfg_q[sel].chan;
endmodule

// File: rtl/xtu_pick.sv
module xtu_pick #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               valid,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] onehot
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        valid = 1'b1;
        idx   = i[IDX_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_oh
    assign onehot[g] = valid && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/xtu_seq.sv
module xtu_seq
  import xtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic              norm_busy,
  input  logic              conv_ack,
  input  logic              conv_eoc,
  output logic              idle,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              norm_hold,
  output logic              eoc_flag
);
  seq_st_t           st_q, st_d;
  logic              req_q, req_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              hold_q, hold_d;
  logic              eocf_q, eocf_d;

  always_comb begin
    st_d   = st_q;
    req_d  = req_q;
    chan_d = chan_q;
    hold_d = hold_q;
    eocf_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_REQ;
        req_d  = 1'b1;
        chan_d = chan_in;
        hold_d = norm_busy;
      end
      ST_REQ: if (conv_ack) begin
        st_d  = ST_CONV;
        req_d = 1'b0;
      end
      ST_CONV: if (conv_eoc) begin
        st_d   = ST_IDLE;
        hold_d = 1'b0;
        eocf_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      chan_q <= '0;
      hold_q <= 1'b0;
      eocf_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_q  <= req_d;
      chan_q <= chan_d;
      hold_q <= hold_d;
      eocf_q <= eocf_d;
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign conv_req  = req_q;
  assign conv_chan = chan_q;
  assign norm_hold = hold_q;
  assign eoc_flag  = eocf_q;

  // R5: an unaccepted request keeps its channel
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_ack) |=> (conv_req && $stable(conv_chan)));

  // R5: no request while a conversion is running
  assert_no_req_in_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONV) |-> !conv_req);

  // R7: the end-of-conversion pulse finds the unit idle
  assert_eoc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_flag |-> (idle && !conv_req && !norm_hold));

  // R8: hold persists until end of conversion
  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_hold && !conv_eoc) |=> norm_hold);
endmodule

// File: rtl/xtrig_unit.sv
module xtrig_unit
  import xtu_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int ADDR_W = $clog2(NUM_SRC),
  localparam int CFG_W  = $bits(cfg_t)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic [NUM_SRC-1:0] src_ack,
  output logic [NUM_SRC-1:0] ovr_flags,
  output logic               conv_req,
  output logic [CHAN_W-1:0]  conv_chan,
  input  logic               conv_ack,
  input  logic               conv_eoc,
  input  logic               norm_busy,
  output logic               norm_hold,
  output logic               eoc_flag
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q   <= rst_m_q;
    end
  end

  logic [NUM_SRC-1:0] en_mask, per_mask, cand, win_oh, live_evt, wr_clr;
  logic [NUM_SRC-1:0] pend_q, pend_d, ovr_q, ovr_d, ack_q, ack_d;
  logic [ADDR_W-1:0]  win_idx;
  logic [CHAN_W-1:0]  win_chan;
  logic               win_valid, idle, issue;
  cfg_t               rd_word;

  xtu_cfg_bank #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_q), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_t'(cfg_wdata)), .rdata(rd_word), .sel(win_idx),
    .sel_chan(win_chan), .en_mask(en_mask), .per_mask(per_mask)
  );
  assign cfg_rdata = rd_word;

  assign live_evt = evt_in & en_mask;
  assign cand     = (pend_q | live_evt) & en_mask;

  xtu_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .cand(cand), .valid(win_valid), .idx(win_idx), .onehot(win_oh)
  );

  assign issue = idle && win_valid;

  xtu_seq u_seq (
    .clk(clk), .rst_n(rst_q), .start(issue), .chan_in(win_chan),
    .norm_busy(norm_busy), .conv_ack(conv_ack), .conv_eoc(conv_eoc),
    .idle(idle), .conv_req(conv_req), .conv_chan(conv_chan),
    .norm_hold(norm_hold), .eoc_flag(eoc_flag)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
    assign wr_clr[g] = cfg_we && (cfg_addr == ADDR_W'(g));
  end

  always_comb begin
    pend_d = pend_q | live_evt;
    if (issue) pend_d = pend_d & ~win_oh;
    pend_d = pend_d & ~wr_clr;
    ovr_d  = (ovr_q | (live_evt & pend_q)) & ~wr_clr;
    ack_d  = issue ? (win_oh & per_mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pend_q <= '0;
      ovr_q  <= '0;
      ack_q  <= '0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
      ack_q  <= ack_d;
    end
  end

  assign src_ack   = ack_q;
  assign ovr_flags = ovr_q;

  // R4: at most one source acknowledged at a time
  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(src_ack));

  // R4: capture-kind sources never see an acknowledge
  assert_ack_kind_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (src_ack & ~$past(per_mask)) == '0);

  // R4: an acknowledge comes with a fresh request
  assert_ack_with_req_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (src_ack != '0) |-> conv_req);
endmodule

// File: tb/xtrig_unit_test.sv
`timescale 1ns/1ps
module xtrig_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [8:0]  cfg_wdata;
  logic [8:0]  cfg_rdata;
  logic [63:0] evt_in, src_ack, ovr_flags;
  logic        conv_req, conv_ack, conv_eoc, norm_busy, norm_hold, eoc_flag;
  logic [6:0]  conv_chan;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  xtrig_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_in(evt_in),
    .src_ack(src_ack), .ovr_flags(ovr_flags), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_ack(conv_ack), .conv_eoc(conv_eoc),
    .norm_busy(norm_busy), .norm_hold(norm_hold), .eoc_flag(eoc_flag)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] word(bit en, bit per, int ch);
    return {en, per, 7'(ch)};
  endfunction

  task automatic cfg_write(int idx, logic [8:0] w);
    cfg_we = 1'b1; cfg_addr = 6'(idx); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(logic [63:0] v);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  // at a negedge where the request is expected up
  task automatic serve(string tag, int ch, logic [63:0] ack_exp);
    chk({tag, " req"}, 64'(conv_req), 64'd1);
    chk({tag, " chan"}, 64'(conv_chan), 64'(ch));
    chk({tag, " ack"}, src_ack, ack_exp);
    conv_ack = 1'b1;
    @(negedge clk);
    conv_ack = 1'b0;
    chk({tag, " R4 ack pulse ends"}, src_ack, 64'd0);
    chk({tag, " R5 req drops"}, 64'(conv_req), 64'd0);
    conv_eoc = 1'b1;
    @(negedge clk);
    conv_eoc = 1'b0;
    chk({tag, " R7 eoc_flag"}, 64'(eoc_flag), 64'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; evt_in = '0;
    conv_ack = 0; conv_eoc = 0; norm_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset req", 64'(conv_req), 64'd0);
    chk("R1 reset ack", src_ack, 64'd0);
    chk("R1 reset ovr", ovr_flags, 64'd0);
    cfg_addr = 6'd63; #0.1;
    chk("R1 reset word", 64'(cfg_rdata), 64'd0);
  endtask

  task automatic t_config();
    cfg_write(3, word(1, 1, 10));
    cfg_write(9, word(1, 0, 20));
    cfg_write(40, word(1, 1, 5));
    cfg_write(12, word(1, 1, 33));
    cfg_write(20, word(1, 0, 99));
    cfg_addr = 6'd9; #0.1;
    chk("R1 readback 9", 64'(cfg_rdata), 64'(word(1, 0, 20)));
    cfg_addr = 6'd40; #0.1;
    chk("R1 readback 40", 64'(cfg_rdata), 64'(word(1, 1, 5)));
  endtask

  task automatic t_basic();
    fire(64'd1 << 3);
    serve("R2 periodic src3", 10, 64'd1 << 3);
    @(negedge clk);
    chk("R2 no extra req", 64'(conv_req), 64'd0);
    fire(64'd1 << 9);
    serve("R4 capture src9", 20, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_disabled();
    fire(64'd1 << 7);
    chk("R2 disabled no req", 64'(conv_req), 64'd0);
    chk("R2 disabled no ack", src_ack, 64'd0);
    fire(64'd1 << 7);
    @(negedge clk);
    chk("R2 disabled no req later", 64'(conv_req), 64'd0);
    chk("R2 disabled no ovr", ovr_flags, 64'd0);
  endtask

  task automatic t_priority();
    fire((64'd1 << 40) | (64'd1 << 9) | (64'd1 << 3));
    serve("R3 first src3", 10, 64'd1 << 3);
    @(negedge clk);
    serve("R3 second src9", 20, 64'd0);
    @(negedge clk);
    serve("R3 third src40", 5, 64'd1 << 40);
    @(negedge clk);
    chk("R3 drained", 64'(conv_req), 64'd0);
    chk("R3 no ovr", ovr_flags, 64'd0);
  endtask

  task automatic t_overrun();
    fire(64'd1 << 12);
    chk("R5 req up", 64'(conv_req), 64'd1);
    fire(64'd1 << 20);
    fire(64'd1 << 20);
    repeat (2) @(negedge clk);
    chk("R5 req held", 64'(conv_req), 64'd1);
    chk("R5 chan held", 64'(conv_chan), 64'd33);
    chk("R6 ovr src20", ovr_flags, 64'd1 << 20);
    chk("R4 single ack pulse", src_ack, 64'd0);
    serve("R6 held src12", 33, 64'd0);
    @(negedge clk);
    serve("R6 pending src20", 99, 64'd0);
    @(negedge clk);
    cfg_write(20, word(1, 0, 99));
    chk("R6 ovr cleared by write", ovr_flags, 64'd0);
  endtask

  task automatic t_wr_clears_pend();
    fire(64'd1 << 3);
    fire(64'd1 << 40);
    cfg_write(40, word(1, 1, 6));
    serve("R6 busy src3", 10, 64'd0);
    @(negedge clk);
    chk("R6 write drops pending", 64'(conv_req), 64'd0);
  endtask

  task automatic t_preempt();
    norm_busy = 1'b1;
    fire(64'd1 << 9);
    norm_busy = 1'b0;
    chk("R8 hold rises", 64'(norm_hold), 64'd1);
    conv_ack = 1'b1;
    @(negedge clk);
    conv_ack = 1'b0;
    chk("R8 hold during conv", 64'(norm_hold), 64'd1);
    @(negedge clk);
    chk("R8 hold still", 64'(norm_hold), 64'd1);
    conv_eoc = 1'b1;
    @(negedge clk);
    conv_eoc = 1'b0;
    chk("R8 hold released", 64'(norm_hold), 64'd0);
    chk("R7 eoc with preempt", 64'(eoc_flag), 64'd1);
    @(negedge clk);
    chk("R7 eoc one cycle", 64'(eoc_flag), 64'd0);
    fire(64'd1 << 9);
    chk("R8 no hold when idle adc", 64'(norm_hold), 64'd0);
    serve("R8 plain", 20, 64'd0);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_config();
    t_basic();
    t_disabled();
    t_priority();
    t_overrun();
    t_wr_clears_pend();
    t_preempt();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule